// File: doc/BRIEF.md
# Configurable Output Macrocell for a Programmable Logic Array

This block is one output cell of a programmable logic array. It takes a group of product terms from the AND plane and ORs them into a single sum. It then passes that sum through a storage stage whose type is set by a static configuration word. The stage can be a bypass, an edge-triggered register or a level-sensitive latch. It drives a split pad interface (value, enable, sampled pad input) and returns a feedback bit to the array.

The capture event for the register or latch comes from one of two sources: a chip-wide clock/enable pin or a product term owned by this cell. Each source has a selectable active polarity. The pad enable likewise comes from a chip-wide pin or from a private product term. A preload strobe can write any value straight into the storage stage, so that test equipment can reach every state.

All control inputs are sampled by the core clock `clk`. A register-mode capture therefore happens on the core clock edge that first sees the selected source at its active level after seeing it inactive.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst` is high, every core clock edge clears the storage stage and forces `pad_oe` low. Reset wins over preload. `pad_oe` stays low until the first core edge that samples `rst` low has passed.
- R2: The sum is the OR of all `NUM_PT` bits of `pt_sum`. Any single bit set gives a sum of 1.
- R3: When `cfg_word[1:0]` is 0 or 3 (bypass), the storage output equals the sum in the same cycle. The clock source and polarity settings have no effect.
- R4: When `cfg_word[1:0]` is 1 (register) and `cfg_word[3]` is 0, the storage stage loads the sum at the core edge that samples the selected source high after the previous edge sampled it low. At every other edge it holds its value.
- R5: When `cfg_word[3]` is 1 in register mode, the capture takes place on a high-to-low change of the selected source instead.
- R6: `cfg_word[2]` selects the clock/enable source: 0 selects `com_clk` and 1 selects `pt_clk`. The source that is not selected has no effect.
- R7: When `cfg_word[1:0]` is 2 (latch), the stage is open while the selected source is at its active level. The active level is high when `cfg_word[3]` is 0 and low when it is 1. While open, the storage output follows the sum combinationally. When closed, it holds the sum sampled at the last core edge at which the stage was open.
- R8: `cfg_word[4]` selects the pad enable: 0 selects `com_oe` and 1 selects `pt_oe`, both active high.
- R9: `pad_out` equals the storage output XOR `cfg_word[5]`.
- R10: `fb` equals the storage output, not inverted, while `pad_oe` is high, and equals `pad_in` while `pad_oe` is low.
- R11: A core edge that samples `pre_en` high loads `pre_data` into the storage stage in every mode. Preload takes priority over a capture at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; samples all control inputs |
| rst | input | 1 | Synchronous active-high reset |
| pt_sum | input | NUM_PT | Product terms feeding the OR sum |
| pt_clk | input | 1 | Private clock/enable product term |
| pt_oe | input | 1 | Private pad-enable product term |
| com_clk | input | 1 | Shared clock/enable pin |
| com_oe | input | 1 | Shared pad-enable pin |
| cfg_word | input | 6 | Static configuration (mode, source, polarity, enable source, pad inversion) |
| pre_en | input | 1 | Preload strobe |
| pre_data | input | 1 | Preload value |
| pad_in | input | 1 | Value sampled at the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb | output | 1 | Feedback to the array |

## Verification
The assertions assume that the clock/enable sources hold each level for at least one core clock period, so that no active level goes unsampled. They also assume that `cfg_word` changes only between core edges and never in the same cycle as an edge it is meant to govern. The stimulus changes every input only at the falling core clock edge. It holds each source level across at least one rising edge, and it changes the configuration one cycle before any event that depends on it. That keeps register, latch and preload events one cycle apart, so the capture cycle of each is unambiguous.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

    typedef enum logic [1:0] {
        MC_BYPASS     = 2'd0,
        MC_REGISTER   = 2'd1,
        MC_LATCH      = 2'd2,
        MC_BYPASS_ALT = 2'd3
    } mc_mode_e;

    typedef struct packed {
        logic     pad_inv;
        logic     oe_from_pt;
        logic     clk_active_low;
        logic     clk_from_pt;
        mc_mode_e mode;
    } mc_cfg_t;

    localparam int unsigned CFG_W = $bits(mc_cfg_t);

    function automatic logic is_bypass(input mc_mode_e m);
        return (m == MC_BYPASS) || (m == MC_BYPASS_ALT);
    endfunction

endpackage

// File: rtl/pld_mc_sum.sv
module pld_mc_sum #(
    parameter int unsigned NUM_PT = 4
) (
    input  logic [NUM_PT-1:0] terms,
    output logic              sum
);
    logic [NUM_PT:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < NUM_PT; i++) begin : g_or
        assign chain[i+1] = chain[i] | terms[i];
    end
    assign sum = chain[NUM_PT];
endmodule

// File: rtl/pld_mc_ctrl.sv
module pld_mc_ctrl
    import pld_mc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  mc_cfg_t cfg,
    input  logic    com_clk,
    input  logic    pt_clk,
    input  logic    com_oe,
    input  logic    pt_oe,
    output logic    lvl,
    output logic    cap_edge,
    output logic    oe
);
    logic src_sel;
    logic lvl_q;
    logic oe_armed;

    assign src_sel  = cfg.clk_from_pt ? pt_clk : com_clk;
    assign lvl      = src_sel ^ cfg.clk_active_low;
    assign cap_edge = lvl & ~lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q    <= 1'b0;
            oe_armed <= 1'b0;
        end else begin
            lvl_q    <= lvl;
            oe_armed <= 1'b1;
        end
    end

    assign oe = oe_armed & (cfg.oe_from_pt ? pt_oe : com_oe);
endmodule

// File: rtl/pld_mc_store.sv
module pld_mc_store
    import pld_mc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mc_mode_e mode,
    input  logic     cap_edge,
    input  logic     lvl,
    input  logic     sop,
    input  logic     pre_en,
    input  logic     pre_data,
    output logic     q,
    output logic     st_out
);
    logic take;

    always_comb begin
        unique case (mode)
            MC_REGISTER: take = cap_edge;
            MC_LATCH:    take = lvl;
            default:     take = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         q <= 1'b0;
        else if (pre_en) q <= pre_data;
        else if (take)   q <= sop;
    end

    always_comb begin
        unique case (mode)
            MC_REGISTER: st_out = q;
            MC_LATCH:    st_out = lvl ? sop : q;
            default:     st_out = sop;
        endcase
    end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import pld_mc_pkg::*;
#(
    parameter int unsigned NUM_PT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PT-1:0] pt_sum,
    input  logic              pt_clk,
    input  logic              pt_oe,
    input  logic              com_clk,
    input  logic              com_oe,
    input  logic [5:0]        cfg_word,
    input  logic              pre_en,
    input  logic              pre_data,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              fb
);
    mc_cfg_t cfg;
    logic    sop;
    logic    lvl;
    logic    cap_edge;
    logic    store_q;
    logic    store_out;

    assign cfg = mc_cfg_t'(cfg_word);

    pld_mc_sum #(.NUM_PT(NUM_PT)) u_sum (
        .terms (pt_sum),
        .sum   (sop)
    );

    pld_mc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .com_clk  (com_clk),
        .pt_clk   (pt_clk),
        .com_oe   (com_oe),
        .pt_oe    (pt_oe),
        .lvl      (lvl),
        .cap_edge (cap_edge),
        .oe       (pad_oe)
    );

    pld_mc_store u_store (
        .clk      (clk),
        .rst      (rst),
        .mode     (cfg.mode),
        .cap_edge (cap_edge),
        .lvl      (lvl),
        .sop      (sop),
        .pre_en   (pre_en),
        .pre_data (pre_data),
        .q        (store_q),
        .st_out   (store_out)
    );

    assign pad_out = store_out ^ cfg.pad_inv;
    assign fb      = pad_oe ? store_out : pad_in;
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       pad_inv,
    input logic       pre_en,
    input logic       pre_data,
    input logic       sop,
    input logic       lvl,
    input logic       cap_edge,
    input logic       store_q,
    input logic       store_out,
    input logic       pad_out,
    input logic       pad_oe,
    input logic       fb
);
    // R1: enable is off in the cycle after any reset edge
    p_oe_off_after_rst_r1: assert property (@(posedge clk)
        $past(rst) |-> !pad_oe);

    // R3: bypass shows the sum
    p_bypass_follows_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 || mode == 2'd3) |-> (store_out == sop));

    // R4: register holds without capture or preload
    p_reg_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && !pre_en && !cap_edge) |=> $stable(store_q));

    // R7: open latch is transparent
    p_latch_open_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && lvl) |-> (store_out == sop));

    // R10: feedback matches the uninverted pad value while driving
    p_fb_driven_r10: assert property (@(posedge clk) disable iff (rst)
        pad_oe |-> (fb == (pad_out ^ pad_inv)));

    // R11: preload value lands in storage
    p_preload_r11: assert property (@(posedge clk) disable iff (rst)
        pre_en |=> (store_q == $past(pre_data)));
endmodule

bind pld_macrocell pld_macrocell_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (cfg_word[1:0]),
    .pad_inv   (cfg_word[5]),
    .pre_en    (pre_en),
    .pre_data  (pre_data),
    .sop       (sop),
    .lvl       (lvl),
    .cap_edge  (cap_edge),
    .store_q   (store_q),
    .store_out (store_out),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .fb        (fb)
);

// File: tb/pld_macrocell_test.sv
module pld_macrocell_test;
    localparam int unsigned PERIOD = 10;
    localparam int unsigned NPT    = 4;

    typedef struct {
        string tag;
        logic  e_out;
        logic  e_oe;
        logic  e_fb;
    } sb_item_t;

    logic           clk = 1'b0;
    logic           rst;
    logic [NPT-1:0] pt_sum;
    logic           pt_clk, pt_oe, com_clk, com_oe;
    logic [5:0]     cfg_word;
    logic           pre_en, pre_data, pad_in;
    logic           pad_out, pad_oe, fb;

    sb_item_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    pld_macrocell #(.NUM_PT(NPT)) uut (
        .clk(clk), .rst(rst), .pt_sum(pt_sum), .pt_clk(pt_clk), .pt_oe(pt_oe),
        .com_clk(com_clk), .com_oe(com_oe), .cfg_word(cfg_word),
        .pre_en(pre_en), .pre_data(pre_data), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .fb(fb)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        #(PERIOD/4);
    endtask

    // expected storage value and enable; pad and feedback derived per R9/R10
    task automatic expect_st(input string tag, input logic st, input logic oe);
        sb_item_t it;
        it.tag   = tag;
        it.e_oe  = oe;
        it.e_out = st ^ cfg_word[5];
        it.e_fb  = oe ? st : pad_in;
        sb.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            sb_item_t it;
            wait (sb.size() != 0);
            it = sb.pop_front();
            n_cmp++;
            if (pad_out !== it.e_out || pad_oe !== it.e_oe || fb !== it.e_fb) begin
                n_bad++;
                $display("FAIL %s: out/oe/fb actual %b%b%b expected %b%b%b",
                         it.tag, pad_out, pad_oe, fb, it.e_out, it.e_oe, it.e_fb);
            end
        end
    end

    initial begin : watchdog
        #(PERIOD * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        rst = 1'b1; pt_sum = '0; pt_clk = 0; pt_oe = 0; com_clk = 0; com_oe = 1;
        cfg_word = 6'b000001; pre_en = 1; pre_data = 1; pad_in = 1;
        tick(); tick(); settle();
        expect_st("R1 reset beats preload", 1'b0, 1'b0);
        tick(); rst = 0; pre_en = 0; settle();
        expect_st("R1 oe still off", 1'b0, 1'b0);
        tick(); settle();
        expect_st("R1 oe armed", 1'b0, 1'b1);

        // register, common clock, rising
        tick(); pt_sum = 4'b0100; settle();
        expect_st("R4 no edge", 1'b0, 1'b1);
        tick(); com_clk = 1; settle();
        expect_st("R4 before capture edge", 1'b0, 1'b1);
        tick(); settle();
        expect_st("R4 captured", 1'b1, 1'b1);
        tick(); pt_sum = 4'b0000;
        tick(); settle();
        expect_st("R4 hold at high level", 1'b1, 1'b1);
        tick(); pt_clk = 1;
        tick(); pt_clk = 0;
        tick(); settle();
        expect_st("R6 unselected pt_clk ignored", 1'b1, 1'b1);

        // falling polarity
        tick(); cfg_word = 6'b001001;
        tick(); settle();
        expect_st("R5 no capture on polarity flip", 1'b1, 1'b1);
        tick(); com_clk = 0; settle();
        tick(); settle();
        expect_st("R5 falling capture", 1'b0, 1'b1);

        // product-term clock, rising
        tick(); cfg_word = 6'b000101; pt_sum = 4'b0001;
        tick(); com_clk = 1;
        tick(); settle();
        expect_st("R6 unselected com_clk ignored", 1'b0, 1'b1);
        tick(); pt_clk = 1;
        tick(); settle();
        expect_st("R6 pt_clk capture", 1'b1, 1'b1);

        // pad inversion and enables
        tick(); cfg_word = 6'b100101; settle();
        expect_st("R9 inverted pad", 1'b1, 1'b1);
        tick(); com_oe = 0; pad_in = 0; settle();
        expect_st("R10 fb from pad low", 1'b1, 1'b0);
        tick(); pad_in = 1; settle();
        expect_st("R10 fb from pad high", 1'b1, 1'b0);
        tick(); cfg_word = 6'b110101; pt_oe = 0; com_oe = 1; settle();
        expect_st("R8 pt_oe low, com_oe ignored", 1'b1, 1'b0);
        tick(); pt_oe = 1; settle();
        expect_st("R8 pt_oe high", 1'b1, 1'b1);

        // preload
        tick(); cfg_word = 6'b010101; pre_en = 1; pre_data = 0;
        tick(); pre_en = 0; pt_clk = 0; settle();
        expect_st("R11 preload zero", 1'b0, 1'b1);
        tick(); pt_clk = 1; pt_sum = 4'b0001; pre_en = 1; pre_data = 0;
        tick(); pre_en = 0; settle();
        expect_st("R11 preload beats capture", 1'b0, 1'b1);
        tick(); settle();
        expect_st("R11 no late capture", 1'b0, 1'b1);
        tick(); pre_en = 1; pre_data = 1;
        tick(); pre_en = 0; settle();
        expect_st("R11 preload one", 1'b1, 1'b1);

        // bypass
        tick(); cfg_word = 6'b010000; pt_sum = 4'b0000; settle();
        expect_st("R3 bypass shows sum zero", 1'b0, 1'b1);
        tick(); pt_clk = 0; com_clk = 0; settle();
        expect_st("R3 clocks ignored", 1'b0, 1'b1);
        for (int i = 0; i < NPT; i++) begin
            tick(); pt_sum = NPT'(1) << i; settle();
            expect_st($sformatf("R2 single term %0d", i), 1'b1, 1'b1);
        end
        tick(); cfg_word = 6'b010011; pt_sum = 4'b0010; settle();
        expect_st("R3 alternate bypass code", 1'b1, 1'b1);

        // latch, active high
        tick(); cfg_word = 6'b010110; pt_sum = 4'b0000; settle();
        expect_st("R7 closed holds", 1'b1, 1'b1);
        tick(); pt_clk = 1; settle();
        expect_st("R7 open transparent zero", 1'b0, 1'b1);
        tick(); pt_sum = 4'b0100; settle();
        expect_st("R7 open transparent one", 1'b1, 1'b1);
        tick(); pt_clk = 0; pt_sum = 4'b0000; settle();
        expect_st("R7 closed keeps last open value", 1'b1, 1'b1);

        // latch, active low
        tick(); cfg_word = 6'b011110; settle();
        expect_st("R7 low-active open", 1'b0, 1'b1);
        tick(); pt_clk = 1; pt_sum = 4'b0001; settle();
        expect_st("R7 low-active closed", 1'b0, 1'b1);
        tick(); pre_en = 1; pre_data = 1;
        tick(); pre_en = 0; settle();
        expect_st("R11 preload closed latch", 1'b1, 1'b1);

        // reset again
        tick(); rst = 1;
        tick(); settle();
        expect_st("R1 reset clears latch", 1'b0, 1'b0);
        tick(); rst = 0;
        tick(); tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule